// File: doc/BRIEF.md
# State Retention Register Bank

This block is a small addressable bank of data words whose storage models a power-gated domain. Each word has a main register, which belongs to the switchable supply and loses its contents when that supply is off, and a shadow copy, which belongs to the always-on supply and keeps its contents through a power-down. One active-low retention control drives both directions of transfer. Its falling edge copies every main word into the shadow. Its rising edge reloads every main word from the shadow.

A power-control sequencer uses the bank in a fixed order. It drops the retention control to save state, turns the switched supply off, turns it back on, and then raises the control to restore. Both control inputs are sampled on the functional clock, which keeps running throughout. While the switched supply is off, the main words hold a defined corrupt pattern. If the control rises before power is back, the bank flags a sequencing error and does not restore.

The asynchronous reset belongs to the switched domain. It clears the main words and leaves the shadow alone, so a bank that is reset while asleep can still restore its saved state afterwards.

Top module: `ret_bank`

## Requirements
- R1: While `rst_n` is low, every word reads 0 and `ret_err` is 0.
- R2: In a cycle where `pwr_on` is 1 and `ret_n` is 1, a clock edge with `wr_en` at 1 writes `wr_data` into word `wr_addr`. `rd_data` always shows word `rd_addr` combinationally.
- R3: The first clock edge that samples `ret_n` low after it was sampled high copies every main word, as it was before that edge, into its shadow.
- R4: While `ret_n` is sampled low, writes have no effect on any word.
- R5: Every clock edge that samples `pwr_on` at 0 loads every word with the corrupt pattern. That pattern has alternating bits with bit 0 set, which is 8'h55 at the default width. Writes are ignored in those cycles.
- R6: The first edge that samples `ret_n` high after it was sampled low restores every word from its shadow, provided that edge also samples `pwr_on` at 1.
- R7: If such a rising edge samples `pwr_on` at 0, `ret_err` is 1 for exactly the following clock cycle and no restore takes place.
- R8: Reset does not disturb the shadow. The first clock edge after reset is released only arms the edge detection, so a restore that comes after the reset returns the values that were saved before it.
- R9: On a restoring edge, the restore wins over a write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; keeps running while the switched supply is off |
| rst_n | input | 1 | Asynchronous active-low reset for the main words |
| ret_n | input | 1 | Active-low retention control; falling edge saves, rising edge restores |
| pwr_on | input | 1 | High while the switched supply is on |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word written |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Word shown on `rd_data` |
| rd_data | output | 8 | Contents of word `rd_addr` |
| ret_err | output | 1 | One-cycle pulse when a restore is requested while the supply is off |

## Verification
A shadow that misses a save, or that reset has touched, is invisible until the next restore. From the edge after the rising control, every word then reads back wrong. A main word that ignores the power state, or takes a write while the control is low, shows up on `rd_data` in the very next cycle. For that reason the bench reads every word through `rd_data` right after each save, each power change and each restore. A misdetected edge appears either as a missing or extra `ret_err` pulse one cycle after the control rises, or as data restored one cycle late.

// File: rtl/ret_pkg.sv
package ret_pkg;

  // Alternating-bit pattern with bit 0 set; sliced to the word width by users.
  function automatic logic [63:0] alt_pattern();
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction

endpackage

// File: rtl/ret_ctl.sv
// Sampled edge detection of the retention control (always-on logic).
module ret_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_n,
  input  logic pwr_on,
  output logic save_evt,
  output logic restore_evt,
  output logic early_evt,
  output logic ret_err
);

  logic ret_q;
  logic armed;
  logic rise;

  // armed blocks a false edge on the first edge after reset (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q   <= 1'b1;
      armed   <= 1'b0;
      ret_err <= 1'b0;
    end else begin
      ret_q   <= ret_n;
      armed   <= 1'b1;
      ret_err <= early_evt;
    end
  end

  assign save_evt    = armed & ret_q & ~ret_n;
  assign rise        = armed & ~ret_q & ret_n;
  assign restore_evt = rise & pwr_on;
  assign early_evt   = rise & ~pwr_on;

endmodule

// File: rtl/ret_word.sv
// One word: main register (switched domain) plus shadow copy (always-on).
module ret_word #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             save,
  input  logic             restore,
  input  logic             wr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] shadow_q
);

  localparam logic [63:0]      ALT     = ret_pkg::alt_pattern();
  localparam logic [WIDTH-1:0] CORRUPT = ALT[WIDTH-1:0];

  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       main_q <= '0;
    else if (!pwr_on) main_q <= CORRUPT;
    else if (restore) main_q <= shadow;
    else if (wr)      main_q <= wr_data;
  end

  // no reset: shadow survives a switched-domain reset
  always_ff @(posedge clk) begin
    if (save) shadow <= main_q;
  end

  assign q        = main_q;
  assign shadow_q = shadow;

endmodule

// File: rtl/ret_bank.sv
module ret_bank #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int AW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_n,
  input  logic             pwr_on,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             ret_err
);

  localparam int FLAT = WIDTH * NREGS;

  logic             save_evt;
  logic             restore_evt;
  logic             early_evt;
  logic             wr_allowed;
  logic [WIDTH-1:0] word_q   [NREGS];
  logic [FLAT-1:0]  main_flat;
  logic [FLAT-1:0]  shadow_flat;

  ret_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_n       (ret_n),
    .pwr_on      (pwr_on),
    .save_evt    (save_evt),
    .restore_evt (restore_evt),
    .early_evt   (early_evt),
    .ret_err     (ret_err)
  );

  assign wr_allowed = wr_en & ret_n;

  for (genvar g = 0; g < NREGS; g++) begin : g_word
    logic wr_sel;
    assign wr_sel = wr_allowed && (wr_addr == AW'(g));
    ret_word #(.WIDTH(WIDTH)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_on   (pwr_on),
      .save     (save_evt),
      .restore  (restore_evt),
      .wr       (wr_sel),
      .wr_data  (wr_data),
      .q        (word_q[g]),
      .shadow_q (shadow_flat[g*WIDTH +: WIDTH])
    );
    assign main_flat[g*WIDTH +: WIDTH] = word_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr == AW'(i)) rd_data = word_q[i];
  end

endmodule

module ret_bank_checker #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ret_n,
  input logic                   pwr_on,
  input logic                   save_evt,
  input logic                   restore_evt,
  input logic                   early_evt,
  input logic                   ret_err,
  input logic [WIDTH*NREGS-1:0] main_flat,
  input logic [WIDTH*NREGS-1:0] shadow_flat
);

  localparam logic [63:0]            ALT     = ret_pkg::alt_pattern();
  localparam logic [WIDTH*NREGS-1:0] ALL_BAD = {NREGS{ALT[WIDTH-1:0]}};

  p_corrupt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (main_flat == ALL_BAD));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !ret_n) |=> $stable(main_flat));

  p_save_r3: assert property (@(posedge clk) disable iff (!rst_n)
    save_evt |=> (shadow_flat == $past(main_flat)));

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_evt |=> (main_flat == $past(shadow_flat)));

  p_early_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> (ret_err && $stable(main_flat)));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |=> !ret_err);

  p_no_stray_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !early_evt |=> !ret_err);

endmodule

bind ret_bank ret_bank_checker #(.WIDTH(WIDTH), .NREGS(NREGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ret_n       (ret_n),
  .pwr_on      (pwr_on),
  .save_evt    (save_evt),
  .restore_evt (restore_evt),
  .early_evt   (early_evt),
  .ret_err     (ret_err),
  .main_flat   (main_flat),
  .shadow_flat (shadow_flat)
);

// File: tb/ret_bank_test.sv
`timescale 1ns/1ps
module ret_bank_test;
  localparam int W = 8;
  localparam int N = 4;
  localparam int A = 2;
  localparam logic [W-1:0] BAD = 8'h55;  // R5 pattern

  logic clk = 0, rst_n = 0, ret_n = 1, pwr_on = 1, wr_en = 0, ret_err;
  logic [A-1:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0, rd_data;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ret_bank uut (.clk(clk), .rst_n(rst_n), .ret_n(ret_n), .pwr_on(pwr_on),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ret_err(ret_err));

  // behavioural reference model
  logic [W-1:0] m_main [N];
  logic [W-1:0] m_shad [N];
  bit m_prev, m_armed, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_main[i]) m_main[i] = '0;
      m_prev = 1; m_armed = 0; m_err = 0;
    end else begin
      bit fall, rise;
      fall = m_armed && m_prev && !ret_n;
      rise = m_armed && !m_prev && ret_n;
      if (fall) foreach (m_main[i]) m_shad[i] = m_main[i];
      m_err = rise && !pwr_on;
      if (!pwr_on) foreach (m_main[i]) m_main[i] = BAD;
      else if (rise) foreach (m_main[i]) m_main[i] = m_shad[i];
      else if (ret_n && wr_en) m_main[wr_addr] = wr_data;
      m_prev = ret_n; m_armed = 1;
    end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model comparison on every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      check("R2 model rd_data", rd_data, m_main[rd_addr]);
      check("R7 model ret_err", {7'd0, ret_err}, {7'd0, m_err});
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic sweep(string tag, logic [W-1:0] exp [N]);
    for (int a = 0; a < N; a++) begin
      cyc(); rd_addr = A'(a); #0.5;
      check(tag, rd_data, exp[a]);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] d1 [N], d2 [N], z [N], bad [N];
    for (int i = 0; i < N; i++) begin
      d1[i] = 8'h3C ^ W'(i * 8'h11);
      d2[i] = 8'hC0 + W'(i);
      z[i] = '0; bad[i] = BAD;
    end
    // R1 reset state
    cyc(); cyc(); #0.5;
    check("R1 rd_data in reset", rd_data, 8'h00);
    check("R1 ret_err in reset", {7'd0, ret_err}, 8'h00);
    cyc(); rst_n = 1;
    sweep("R1 words after reset", z);
    // R2 writes
    for (int i = 0; i < N; i++) begin
      cyc(); wr_en = 1; wr_addr = A'(i); wr_data = d1[i];
    end
    cyc(); wr_en = 0;
    sweep("R2 readback", d1);
    // R3 save, R4 writes blocked while low
    cyc(); ret_n = 0;
    cyc(); wr_en = 1; wr_addr = 0; wr_data = 8'hFF;
    cyc(); wr_addr = 2; wr_data = 8'hEE;
    cyc(); wr_en = 0;
    sweep("R4 writes ignored", d1);
    // R5 power off
    cyc(); pwr_on = 0; wr_en = 1; wr_addr = 1; wr_data = 8'h77;
    cyc(); wr_en = 0;
    sweep("R5 corrupt while off", bad);
    // R6 restore, R9 same-cycle write loses
    cyc(); pwr_on = 1;
    cyc(); ret_n = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h99;
    cyc(); wr_en = 0; #0.5;
    check("R7 no error on legal restore", {7'd0, ret_err}, 8'h00);
    sweep("R6 R3 restored data", d1);
    cyc(); rd_addr = 1; #0.5;
    check("R9 restore beats write", rd_data, d1[1]);
    // R7 early rise while off
    cyc(); ret_n = 0;
    cyc(); pwr_on = 0;
    cyc(); ret_n = 1;
    cyc(); #0.5;
    check("R7 error pulse", {7'd0, ret_err}, 8'h01);
    cyc(); #0.5;
    check("R7 error one cycle", {7'd0, ret_err}, 8'h00);
    cyc(); pwr_on = 1;
    sweep("R7 no restore on early rise", bad);
    // R8 reset during retention keeps shadow
    for (int i = 0; i < N; i++) begin
      cyc(); wr_en = 1; wr_addr = A'(i); wr_data = d2[i];
    end
    cyc(); wr_en = 0;
    cyc(); ret_n = 0;
    cyc(); cyc(); rst_n = 0; rd_addr = 3; #0.5;
    check("R8 reset clears main", rd_data, 8'h00);
    cyc(); cyc(); rst_n = 1;
    cyc(); cyc();
    sweep("R8 cleared until restore", z);
    cyc(); ret_n = 1;
    sweep("R8 shadow survived reset", d2);
    cyc(); cyc();
    finish_run();
  end
endmodule